// File: doc/BRIEF.md
# Instruction Queue Status Tracker

This block sits beside a prefetching processor and follows the progress of its instruction stream. On every clock it samples the 2-bit queue status code that the processor drives, and it keeps its own model of the processor's prefetch queue. Bytes enter the model when a code-fetch bus cycle is seen, which is marked by a fetched-byte strobe with its data. The status code then removes bytes from the model in arrival order, or flushes the model.

For every byte the processor consumes, the tracker presents that byte and marks it as either the opening byte of an instruction or a later byte of the same instruction. It also signals each queue flush and reports how many bytes the model holds. Logic that traces execution or checks instruction boundaries can then rebuild the boundary sequence without decoding instruction lengths. Two sticky error flags report when the observed stream does not agree with the model: a consume while the model is empty, or a fetch while it is full.

Top module: `qst_tracker`

## Requirements
- R1: After reset, `occupancy`, `cons_byte`, `cons_first`, `cons_later`, `flush_seen`, `err_empty` and `err_full` are all zero.
- R2: Status code 2'b00 removes nothing. The next cycle has `cons_first`, `cons_later` and `flush_seen` low, and `occupancy` changes only by an accepted fetch.
- R3: Status code 2'b01 with a non-empty model removes the oldest byte. After that edge, `cons_byte` holds that byte, `cons_first` is 1 and `cons_later` is 0, for one cycle. Bytes come out in the order they were fetched.
- R4: Status code 2'b11 with a non-empty model removes the oldest byte. After that edge, `cons_byte` holds that byte, `cons_later` is 1 and `cons_first` is 0, for one cycle.
- R5: Status code 2'b10 empties the model. After that edge, `flush_seen` is 1 for one cycle and `occupancy` is 0. If a byte is fetched in the same cycle, `occupancy` is 1 and that byte is the next one consumed.
- R6: A fetch strobe (`fetch_vld` high) into a model that is not full stores `fetch_byte` and raises `occupancy` by one.
- R7: A consume code (2'b01 or 2'b11) while `occupancy` is 0 sets `err_empty`, which stays set until reset. `cons_first` and `cons_later` stay low, and no byte is removed.
- R8: A fetch while the model holds DEPTH bytes and no byte leaves in that cycle sets `err_full`, which stays set until reset. The byte is dropped and `occupancy` stays at DEPTH.
- R9: A successful consume and a fetch in the same cycle leave `occupancy` unchanged, even when the model is full.
- R10: Every output changes only at the clock edge where its causing inputs are sampled, and `occupancy` never exceeds DEPTH (default 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; status and fetch inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| qs_code | input | 2 | Queue status code from the processor |
| fetch_vld | input | 1 | High for one cycle per code byte fetched into the queue |
| fetch_byte | input | 8 | Code byte fetched, valid with `fetch_vld` |
| cons_byte | output | 8 | Byte most recently consumed |
| cons_first | output | 1 | Consumed byte opens an instruction |
| cons_later | output | 1 | Consumed byte is a later byte of an instruction |
| flush_seen | output | 1 | Queue flush observed in the previous cycle |
| occupancy | output | 3 | Bytes held in the model |
| err_empty | output | 1 | Sticky: consume seen while the model was empty |
| err_full | output | 1 | Sticky: fetch seen while the model was full |

## Verification
The assertions assume that `qs_code`, `fetch_vld` and `fetch_byte` are known two-state values at every sampling edge. They also assume these inputs change only away from the rising edge, so that each edge sees exactly one status code and at most one fetch. The stimulus drives all inputs on the falling edge from the bench's random generator, with a fixed seed. It keeps the inputs idle during reset and for a few cycles after release, which covers the internal reset synchroniser. Directed sequences push the model to full and to empty so that the overflow, underflow and flush-with-fetch cases are reached on purpose and not by chance.

// File: rtl/qst_pkg.sv
package qst_pkg;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_LATER = 2'b11
  } qs_code_e;

  function automatic logic qs_is_consume(input logic [1:0] code);
    return (code == QS_FIRST) || (code == QS_LATER);
  endfunction

endpackage

// File: rtl/qst_rst_sync.sv
module qst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/qst_ctrl.sv
module qst_ctrl
  import qst_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    qs_code,
  input  logic          fetch_vld,
  input  logic [CW-1:0] count,
  output logic          clr,
  output logic          push,
  output logic          pop,
  output logic          mark_first,
  output logic          mark_later,
  output logic          evt_empty,
  output logic          evt_full,
  output logic [CW-1:0] count_nxt
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_CNT  = CW'(1);

  logic consume;
  logic is_empty;
  logic is_full;

  always_comb begin
    consume    = qs_is_consume(qs_code);
    is_empty   = (count == '0);
    is_full    = (count == FULL_CNT);
    clr        = (qs_code == QS_FLUSH);
    pop        = consume && !is_empty;
    evt_empty  = consume && is_empty;
    mark_first = pop && (qs_code == QS_FIRST);
    mark_later = pop && (qs_code == QS_LATER);
    push       = fetch_vld && (clr || !is_full || pop);
    evt_full   = fetch_vld && !push;

    if (clr) begin
      count_nxt = push ? ONE_CNT : '0;
    end else begin
      unique case ({push, pop})
        2'b10:   count_nxt = count + ONE_CNT;
        2'b01:   count_nxt = count - ONE_CNT;
        default: count_nxt = count;
      endcase
    end
  end

endmodule

// File: rtl/qst_store.sv
module qst_store #(
  parameter int DEPTH = 6,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d;
  logic [PW-1:0] wr_q, wr_d;
  logic [PW-1:0] wr_at;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_at = clr ? '0 : wr_q;
    if (clr) begin
      rd_d = '0;
      wr_d = push ? PW'(1) : '0;
    end else begin
      rd_d = pop  ? wrap_inc(rd_q) : rd_q;
      wr_d = push ? wrap_inc(wr_q) : wr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (wr_at == PW'(i))) mem[i] <= din;
      end
    end
  endgenerate

  assign head = mem[rd_q];

endmodule

// File: rtl/qst_tracker.sv
module qst_tracker
  import qst_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    qs_code,
  input  logic          fetch_vld,
  input  logic [DW-1:0] fetch_byte,
  output logic [DW-1:0] cons_byte,
  output logic          cons_first,
  output logic          cons_later,
  output logic          flush_seen,
  output logic [CW-1:0] occupancy,
  output logic          err_empty,
  output logic          err_full
);

  logic          rst_sn;
  logic          clr, push, pop;
  logic          mark_first, mark_later;
  logic          evt_empty, evt_full;
  logic [CW-1:0] count_q, count_d;
  logic [DW-1:0] head;
  logic [DW-1:0] byte_q, byte_d;
  logic          first_q, later_q, flush_q;
  logic          eempty_q, eempty_d;
  logic          efull_q, efull_d;

  qst_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  qst_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .qs_code    (qs_code),
    .fetch_vld  (fetch_vld),
    .count      (count_q),
    .clr        (clr),
    .push       (push),
    .pop        (pop),
    .mark_first (mark_first),
    .mark_later (mark_later),
    .evt_empty  (evt_empty),
    .evt_full   (evt_full),
    .count_nxt  (count_d)
  );

  qst_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk    (clk),
    .rst_sn (rst_sn),
    .clr    (clr),
    .push   (push),
    .pop    (pop),
    .din    (fetch_byte),
    .head   (head)
  );

  always_comb begin
    byte_d   = pop ? head : byte_q;
    eempty_d = eempty_q || evt_empty;
    efull_d  = efull_q  || evt_full;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      count_q  <= '0;
      byte_q   <= '0;
      first_q  <= 1'b0;
      later_q  <= 1'b0;
      flush_q  <= 1'b0;
      eempty_q <= 1'b0;
      efull_q  <= 1'b0;
    end else begin
      count_q  <= count_d;
      byte_q   <= byte_d;
      first_q  <= mark_first;
      later_q  <= mark_later;
      flush_q  <= clr;
      eempty_q <= eempty_d;
      efull_q  <= efull_d;
    end
  end

  assign cons_byte  = byte_q;
  assign cons_first = first_q;
  assign cons_later = later_q;
  assign flush_seen = flush_q;
  assign occupancy  = count_q;
  assign err_empty  = eempty_q;
  assign err_full   = efull_q;

endmodule

// File: rtl/qst_checker.sv
module qst_checker #(
  parameter int DEPTH = 6,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_sn,
  input logic [1:0]    qs_code,
  input logic          fetch_vld,
  input logic          cons_first,
  input logic          cons_later,
  input logic          flush_seen,
  input logic [CW-1:0] occupancy,
  input logic          err_empty,
  input logic          err_full
);

  // R10: model never holds more than DEPTH bytes
  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_sn)
    occupancy <= CW'(DEPTH));

  // R2 R3 R4 R5: at most one consume/flush marker per cycle
  a_r2_one_marker: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({cons_first, cons_later, flush_seen}));

  // R3
  a_r3_first: assert property (@(posedge clk) disable iff (!rst_sn)
    (qs_code == 2'b01 && occupancy != '0) |=> cons_first);

  // R4
  a_r4_later: assert property (@(posedge clk) disable iff (!rst_sn)
    (qs_code == 2'b11 && occupancy != '0) |=> cons_later);

  // R5
  a_r5_flush: assert property (@(posedge clk) disable iff (!rst_sn)
    (qs_code == 2'b10) |=> (flush_seen && occupancy == CW'($past(fetch_vld))));

  // R7
  a_r7_empty_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    err_empty |=> err_empty);

  a_r7_empty_set: assert property (@(posedge clk) disable iff (!rst_sn)
    (qs_code[0] && occupancy == '0) |=> (err_empty && !cons_first && !cons_later));

  // R8
  a_r8_full_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    err_full |=> err_full);

  a_r8_full_set: assert property (@(posedge clk) disable iff (!rst_sn)
    (fetch_vld && occupancy == CW'(DEPTH) && !qs_code[0] && !qs_code[1])
      |=> (err_full && occupancy == CW'(DEPTH)));

  // R9
  a_r9_balance: assert property (@(posedge clk) disable iff (!rst_sn)
    (fetch_vld && qs_code[0] && occupancy != '0) |=> $stable(occupancy));

endmodule

bind qst_tracker qst_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .qs_code    (qs_code),
  .fetch_vld  (fetch_vld),
  .cons_first (cons_first),
  .cons_later (cons_later),
  .flush_seen (flush_seen),
  .occupancy  (occupancy),
  .err_empty  (err_empty),
  .err_full   (err_full)
);

// File: tb/sim_qst_tracker.sv
module sim_qst_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6;
  localparam int DW         = 8;
  localparam int CW         = $clog2(DEPTH + 1);

  logic          clk;
  logic          rst_n;
  logic [1:0]    qs_code;
  logic          fetch_vld;
  logic [DW-1:0] fetch_byte;
  logic [DW-1:0] cons_byte;
  logic          cons_first, cons_later, flush_seen;
  logic [CW-1:0] occupancy;
  logic          err_empty, err_full;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DW-1:0] mq[$];
  logic [DW-1:0] e_byte;
  logic          e_first, e_later, e_flush, e_empty, e_full;

  qst_tracker #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .qs_code(qs_code), .fetch_vld(fetch_vld),
    .fetch_byte(fetch_byte), .cons_byte(cons_byte), .cons_first(cons_first),
    .cons_later(cons_later), .flush_seen(flush_seen), .occupancy(occupancy),
    .err_empty(err_empty), .err_full(err_full)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected-state model, applied once per sampled edge
  function automatic void model(input logic [1:0] qs, input logic fv, input logic [DW-1:0] fb);
    e_first = 1'b0; e_later = 1'b0; e_flush = 1'b0;
    if (qs == 2'b10) begin
      mq.delete();
      e_flush = 1'b1;
      if (fv) mq.push_back(fb);
    end else begin
      if (qs == 2'b01 || qs == 2'b11) begin
        if (mq.size() == 0) e_empty = 1'b1;
        else begin
          e_byte  = mq.pop_front();
          e_first = (qs == 2'b01);
          e_later = (qs == 2'b11);
        end
      end
      if (fv) begin
        if (mq.size() < DEPTH) mq.push_back(fb);
        else e_full = 1'b1;
      end
    end
  endfunction

  function automatic string tag_of(input logic [1:0] qs, input logic fv);
    if (qs == 2'b10) return "R5";
    if (qs == 2'b01) return fv ? "R9" : "R3";
    if (qs == 2'b11) return fv ? "R9" : "R4";
    return fv ? "R6" : "R2";
  endfunction

  task automatic compare_all(input string t);
    chk(t, "occupancy", int'(occupancy), mq.size());
    chk(t, "cons_first", int'(cons_first), int'(e_first));
    chk(t, "cons_later", int'(cons_later), int'(e_later));
    chk(t, "flush_seen", int'(flush_seen), int'(e_flush));
    chk(t, "cons_byte", int'(cons_byte), int'(e_byte));
    chk("R7", "err_empty", int'(err_empty), int'(e_empty));
    chk("R8", "err_full", int'(err_full), int'(e_full));
  endtask

  task automatic step(input logic [1:0] qs, input logic fv, input logic [DW-1:0] fb);
    @(negedge clk);
    qs_code = qs; fetch_vld = fv; fetch_byte = fb;
    model(qs, fv, fb);
    @(posedge clk);
    #1;
    compare_all(tag_of(qs, fv));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; qs_code = 2'b00; fetch_vld = 1'b0; fetch_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mq.delete();
    e_byte = '0; e_first = 0; e_later = 0; e_flush = 0; e_empty = 0; e_full = 0;
    compare_all("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1; qs_code = 2'b00; fetch_vld = 1'b0; fetch_byte = '0;
    do_reset();

    // R2: idle code on empty model
    step(2'b00, 1'b0, 8'h00);
    // R6: fill to full with distinct bytes
    for (int i = 0; i < DEPTH; i++) step(2'b00, 1'b1, 8'h10 + 8'(i));
    // R8: overflow, byte dropped
    step(2'b00, 1'b1, 8'hEE);
    // R9: full with consume and fetch together
    step(2'b01, 1'b1, 8'h5A);
    // R3 R4: drain in order
    step(2'b11, 1'b0, 8'h00);
    for (int i = 0; i < DEPTH - 1; i++) step((i % 2) ? 2'b01 : 2'b11, 1'b0, 8'h00);
    // R7: underflow on empty, with a fetch in the same cycle
    step(2'b01, 1'b1, 8'h77);
    step(2'b11, 1'b0, 8'h00);
    // R5: flush with and without fetch
    step(2'b00, 1'b1, 8'h31);
    step(2'b00, 1'b1, 8'h32);
    step(2'b10, 1'b1, 8'hA5);
    step(2'b01, 1'b0, 8'h00);
    step(2'b00, 1'b1, 8'h41);
    step(2'b10, 1'b0, 8'h00);
    step(2'b00, 1'b0, 8'h00);

    // R1: reset clears sticky errors
    do_reset();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [1:0] qs;
      r  = int'($urandom_range(0, 99));
      qs = (r < 40) ? 2'b00 : (r < 65) ? 2'b01 : (r < 92) ? 2'b11 : 2'b10;
      step(qs, ($urandom_range(0, 99) < 55), 8'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule